// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block sits between a processor's load/store unit and an external bus whose memory ports come in three widths: 8, 16 and 32 bits. It takes one operand request at a time. The operand can be one, two, three or four bytes long and can start at any byte address. The block breaks the request into the fewest bus cycles that move every byte. Each addressed port answers every cycle with an acknowledge that also gives its width. After each acknowledged cycle the block works out again how many bytes that cycle moved and where the next cycle starts. A single operand can therefore take one, two, three or four cycles.

The bus is big-endian. The operand's most significant byte goes first, at the lowest address. Byte lane 0 is bits 31:24 of the bus. For writes, the block places the operand bytes on the lanes so that a port of any width finds its bytes on the lanes it is wired to. For reads, it picks bytes from the lanes that match the port width and the address offset, and builds a right-justified operand from them. A one-cycle completion pulse ends each transfer, and the next request can be accepted in that same cycle.

Top module: `dbsSequencer`

## Requirements
- R1: The number of bus cycles for an operand is the minimum needed. Each cycle moves the smaller of two counts: the bytes still owed, and the bytes from the address to the next boundary of the acknowledged port width. The port code is 00 for 32-bit, 01 for 8-bit and 10 for 16-bit. So an aligned long on a 32-bit port takes 1 cycle, any long on an 8-bit port takes 4, and a long at an odd address on a 16-bit port takes 3.
- R2: The first bus cycle of an operand drives the request address. Each later cycle drives that address plus the bytes moved so far.
- R3: The bus size output in every cycle codes the bytes still owed: 01 one, 10 two, 11 three, 00 four. The request size uses the same code.
- R4: On a write, the operand byte for address A is driven on lane (A mod port bytes) + 0 for every port width. Lane n is bits 31-8n down to 24-8n. The operand's most significant byte goes to the lowest address.
- R5: On a read, the completed operand is right-justified on the read data output, with the byte from the lowest address as most significant. It is gathered only from the lanes named in R4.
- R6: The bus-cycle indicator is high from the clock after acceptance until the final acknowledge. The done output is a single-cycle pulse in the clock after the final acknowledge, and the bus-cycle indicator is low in that cycle.
- R7: While no acknowledge is sampled, the bus address and size hold steady and no new cycle begins.
- R8: A request raised while a transfer is in progress is ignored. No extra bus cycle follows the transfer.
- R9: During reset and just after it, the bus-cycle indicator and done are low. Requests raised during reset are discarded.
- R10: An acknowledge carrying port code 11 is treated as no acknowledge. The cycle is held unchanged.
- R11: A request presented in the cycle where done is high is accepted. Its first bus cycle starts in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Operand request strobe, taken when idle |
| reqAddr | input | ADDR_W | Operand start byte address |
| reqSize | input | 2 | Operand size code (01/10/11/00 = 1/2/3/4 bytes) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWData | input | 32 | Right-justified write operand |
| busCyc | output | 1 | Bus cycle in progress |
| busAddr | output | ADDR_W | Byte address of the current cycle |
| busSize | output | 2 | Remaining-size code of the current cycle |
| busWrite | output | 1 | Direction of the current cycle |
| busWData | output | 32 | Write data on byte lanes |
| busRData | input | 32 | Read data from byte lanes |
| busAck | input | 1 | Cycle acknowledge |
| busPortSize | input | 2 | Width code of the acknowledging port |
| done | output | 1 | Transfer complete pulse |
| rdData | output | 32 | Assembled read operand, valid with done |

## Verification
The end of one transfer and the acceptance of the next can fall in the same clock. The completion pulse is high while the control sits idle and samples a waiting request. The bench holds the request line high from the start of a one-byte write until after its done cycle, then checks three things. The second operand's bus cycle must begin in the clock right after done, at the new address. Both bytes must land in memory. No third operand may appear. The request held during the first transfer's own bus cycle must not start anything early.

// File: rtl/dbsPkg.sv
package dbsPkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [1:0] {
    PORT32   = 2'b00,
    PORT8    = 2'b01,
    PORT16   = 2'b10,
    PORTNONE = 2'b11
  } portCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;    // accept a new operand
    logic       step;    // an acknowledged cycle completes
    logic [2:0] nMove;   // bytes moved by the current cycle
    logic [1:0] rdLane;  // first lane the port presents
    logic [1:0] addrLo;  // current address offset in the bus word
  } seqStrobe_t;

  function automatic logic [2:0] portBytes(input logic [1:0] code);
    case (code)
      PORT32:  portBytes = 3'd4;
      PORT16:  portBytes = 3'd2;
      PORT8:   portBytes = 3'd1;
      default: portBytes = 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] sizeCount(input logic [1:0] code);
    sizeCount = (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

  function automatic logic [7:0] laneByte(input logic [BUS_W-1:0] data, input logic [1:0] lane);
    laneByte = data[BUS_W-1-8*int'(lane) -: 8];
  endfunction
endpackage

// File: rtl/dbsCtrl.sv
module dbsCtrl
  import dbsPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              busAck,
  input  logic [1:0]        busPortSize,
  output logic              busCyc,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic              done,
  output seqStrobe_t        strobe
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e            stateQ;
  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        remQ;
  logic              writeQ;
  logic              doneQ;

  logic [2:0] pBytes;
  logic [2:0] offset;
  logic [2:0] room;
  logic [2:0] nMove;
  logic       ackOk;
  logic       accept;
  logic       lastStep;

  always_comb begin
    pBytes = portBytes(busPortSize);
    case (pBytes)
      3'd4:    offset = {1'b0, addrQ[1:0]};
      3'd2:    offset = {2'b00, addrQ[0]};
      default: offset = 3'd0;
    endcase
    room     = pBytes - offset;
    nMove    = (remQ < room) ? remQ : room;
    ackOk    = (stateQ == S_RUN) && busAck && (busPortSize != PORTNONE);
    accept   = (stateQ == S_IDLE) && reqValid;
    lastStep = ackOk && (remQ == nMove);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      addrQ  <= '0;
      remQ   <= 3'd0;
      writeQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (accept) begin
        stateQ <= S_RUN;
        addrQ  <= reqAddr;
        remQ   <= sizeCount(reqSize);
        writeQ <= reqWrite;
      end else if (ackOk) begin
        addrQ <= addrQ + ADDR_W'(nMove);
        remQ  <= remQ - nMove;
        if (lastStep) stateQ <= S_IDLE;
      end
    end
  end

  assign busCyc   = (stateQ == S_RUN);
  assign busAddr  = addrQ;
  assign busSize  = remQ[1:0];
  assign busWrite = writeQ;
  assign done     = doneQ;

  assign strobe.load   = accept;
  assign strobe.step   = ackOk;
  assign strobe.nMove  = nMove;
  assign strobe.rdLane = offset[1:0];
  assign strobe.addrLo = addrQ[1:0];
endmodule

// File: rtl/dbsData.sv
module dbsData
  import dbsPkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  input  logic [1:0]       reqSize,
  input  logic [BUS_W-1:0] reqWData,
  input  logic [BUS_W-1:0] busRData,
  output logic [BUS_W-1:0] busWData,
  output logic [BUS_W-1:0] rdData
);
  logic [BUS_W-1:0] wRegQ;     // unsent bytes, left-justified
  logic [BUS_W-1:0] accQ;      // received bytes, right-justified
  logic [BUS_W-1:0] gathered;
  logic [5:0]       loadShift;
  logic [5:0]       stepShift;

  always_comb begin
    loadShift = {3'(3'd4 - sizeCount(reqSize)), 3'b000};
    stepShift = {strobe.nMove, 3'b000};
    gathered  = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (3'(k) < strobe.nMove)
        gathered = {gathered[BUS_W-9:0], laneByte(busRData, strobe.rdLane + 2'(k))};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wRegQ <= '0;
      accQ  <= '0;
    end else if (strobe.load) begin
      wRegQ <= reqWData << loadShift;
      accQ  <= '0;
    end else if (strobe.step) begin
      wRegQ <= wRegQ << stepShift;
      accQ  <= (accQ << stepShift) | gathered;
    end
  end

  // each lane carries the byte that a 32-, 16- or 8-bit port expects there
  for (genvar L = 0; L < BUS_BYTES; L++) begin : g_lane
    logic [1:0] srcIdx;
    always_comb begin
      if (2'(L) >= strobe.addrLo)
        srcIdx = 2'(L) - strobe.addrLo;
      else if (1'(L % 2) >= strobe.addrLo[0])
        srcIdx = 2'(L % 2) - {1'b0, strobe.addrLo[0]};
      else
        srcIdx = 2'd0;
    end
    assign busWData[BUS_W-1-8*L -: 8] = laneByte(wRegQ, srcIdx);
  end

  assign rdData = accQ;
endmodule

// File: rtl/dbsSequencer.sv
module dbsSequencer
  import dbsPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWData,
  output logic              busCyc,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [31:0]       busWData,
  input  logic [31:0]       busRData,
  input  logic              busAck,
  input  logic [1:0]        busPortSize,
  output logic              done,
  output logic [31:0]       rdData
);
  seqStrobe_t strobe;

  dbsCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .busAck(busAck), .busPortSize(busPortSize),
    .busCyc(busCyc), .busAddr(busAddr), .busSize(busSize), .busWrite(busWrite),
    .done(done), .strobe(strobe)
  );

  dbsData u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqSize(reqSize), .reqWData(reqWData),
    .busRData(busRData), .busWData(busWData), .rdData(rdData)
  );
endmodule

// File: rtl/dbsSequencerChk.sv
module dbsSequencerChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busCyc,
  input logic              busAck,
  input logic [1:0]        busPortSize,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              done
);
  logic       ackOk;
  logic [2:0] cycCnt;

  assign ackOk = busCyc && busAck && (busPortSize != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cycCnt <= 3'd0;
    else if (done)   cycCnt <= 3'd0;
    else if (ackOk)  cycCnt <= cycCnt + 3'd1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busCyc && !busAck |=> busCyc && $stable(busAddr) && $stable(busSize));

  // R10
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busCyc && busAck && busPortSize == 2'b11 |=> busCyc && $stable(busAddr) && $stable(busSize));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busCyc && $past(busCyc));

  // R2
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackOk |=> !busCyc || busAddr != $past(busAddr));

  // R1
  cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycCnt >= 3'd1 && cycCnt <= 3'd4);
endmodule

bind dbsSequencer dbsSequencerChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busCyc(busCyc), .busAck(busAck),
  .busPortSize(busPortSize), .busAddr(busAddr), .busSize(busSize), .done(done)
);

// File: tb/dbsSequencer_bench.sv
`timescale 1ns/1ps
module dbsSequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWData = '0;
  logic        busCyc;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic        busWrite;
  logic [31:0] busWData;
  logic [31:0] busRData = '0;
  logic        busAck = 1'b0;
  logic [1:0]  busPortSize = '0;
  logic        done;
  logic [31:0] rdData;

  int testCnt = 0;
  int failCnt = 0;
  logic [7:0] mem [16];
  localparam logic [31:0] BASE = 32'h0000_0100;

  typedef struct packed {
    logic [1:0]  off;
    logic [2:0]  size;
    logic [2:0]  portB;
    logic        wr;
    logic [31:0] data;
    logic [2:0]  cyc;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd0, 3'd4, 3'd4, 1'b0, 32'h0,         3'd1},
    '{2'd0, 3'd4, 3'd1, 1'b1, 32'hA1B2C3D4,  3'd4},
    '{2'd1, 3'd4, 3'd2, 1'b0, 32'h0,         3'd3},
    '{2'd3, 3'd4, 3'd1, 1'b0, 32'h0,         3'd4},
    '{2'd1, 3'd2, 3'd2, 1'b1, 32'h0000BEEF,  3'd2},
    '{2'd3, 3'd2, 3'd4, 1'b0, 32'h0,         3'd2},
    '{2'd1, 3'd2, 3'd4, 1'b1, 32'h00001357,  3'd1},
    '{2'd2, 3'd4, 3'd4, 1'b1, 32'h89ABCDEF,  3'd2},
    '{2'd2, 3'd4, 3'd2, 1'b0, 32'h0,         3'd2},
    '{2'd1, 3'd4, 3'd4, 1'b0, 32'h0,         3'd2},
    '{2'd3, 3'd1, 3'd4, 1'b1, 32'h0000007E,  3'd1},
    '{2'd2, 3'd3, 3'd2, 1'b1, 32'h00112233,  3'd2},
    '{2'd1, 3'd3, 3'd4, 1'b0, 32'h0,         3'd1},
    '{2'd0, 3'd2, 3'd1, 1'b0, 32'h0,         3'd2}
  };

  dbsSequencer u_dbsSequencer (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWData(reqWData),
    .busCyc(busCyc), .busAddr(busAddr), .busSize(busSize), .busWrite(busWrite),
    .busWData(busWData), .busRData(busRData), .busAck(busAck),
    .busPortSize(busPortSize), .done(done), .rdData(rdData)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] codeOf(input int pb);
    if (pb == 4)      codeOf = 2'b00;
    else if (pb == 2) codeOf = 2'b10;
    else              codeOf = 2'b01;
  endfunction

  task automatic runVec(input vec_t v, input int stall, input bit poke);
    int pb, rem, cyc, o, n;
    logic [31:0] ea, expVal;
    pb = int'(v.portB);
    for (int i = 0; i < 16; i++) mem[i] = v.wr ? 8'h00 : 8'(8'h40 + i * 7);
    reqAddr = BASE + 32'(v.off); reqSize = v.size[1:0];
    reqWrite = v.wr; reqWData = v.data; reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    ea = BASE + 32'(v.off); rem = int'(v.size); cyc = 0;
    while (rem > 0 && cyc < 8) begin
      check(busCyc == 1'b1, "R6 busCyc high during transfer", 32'(busCyc), 32'd1);
      check(busAddr == ea, "R2 bus address", busAddr, ea);
      check(busSize == 2'(rem), "R3 remaining size code", 32'(busSize), 32'(2'(rem)));
      if (cyc == 0) begin
        for (int w = 0; w < stall; w++) begin
          busAck = (w == 0); busPortSize = (w == 0) ? 2'b11 : 2'b00;
          @(posedge clk); @(negedge clk);
          check(busCyc && busAddr == ea && busSize == 2'(rem),
                (w == 0) ? "R10 code 11 ack ignored" : "R7 held without ack", busAddr, ea);
        end
      end
      o = int'(ea % 32'(pb));
      n = (rem < pb - o) ? rem : pb - o;
      busRData = 32'hEEEE_EEEE;
      for (int k = 0; k < n; k++) begin
        if (v.wr) mem[4'(ea[3:0] + 4'(k))] = busWData[31-8*(o+k) -: 8];
        else      busRData[31-8*(o+k) -: 8] = mem[4'(ea[3:0] + 4'(k))];
      end
      busAck = 1'b1; busPortSize = codeOf(pb);
      if (poke && cyc == 1) begin
        reqValid = 1'b1; reqAddr = BASE + 32'h8;
      end
      @(posedge clk); @(negedge clk);
      busAck = 1'b0; reqValid = 1'b0;
      ea = ea + 32'(n); rem = rem - n; cyc++;
    end
    check(done == 1'b1, "R6 done after final ack", 32'(done), 32'd1);
    check(busCyc == 1'b0, "R6 busCyc low with done", 32'(busCyc), 32'd0);
    check(cyc == int'(v.cyc), "R1 bus cycle count", 32'(cyc), 32'(v.cyc));
    if (v.wr) begin
      for (int j = 0; j < int'(v.size); j++)
        check(mem[4'(32'(v.off) + 32'(j))] == v.data[8*(int'(v.size)-1-j) +: 8],
              "R4 written byte", 32'(mem[4'(32'(v.off) + 32'(j))]),
              32'(v.data[8*(int'(v.size)-1-j) +: 8]));
    end else begin
      expVal = '0;
      for (int j = 0; j < int'(v.size); j++)
        expVal = (expVal << 8) | 32'(mem[4'(32'(v.off) + 32'(j))]);
      check(rdData == expVal, "R5 assembled read operand", rdData, expVal);
    end
    @(negedge clk);
    check(done == 1'b0, "R6 done lasts one cycle", 32'(done), 32'd0);
    check(busCyc == 1'b0, poke ? "R8 busy request ignored" : "R8 no extra cycle",
          32'(busCyc), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    // R9 reset state, request raised during reset
    reqValid = 1'b1; reqSize = 2'b00; reqAddr = BASE;
    repeat (3) @(negedge clk);
    check(busCyc == 1'b0 && done == 1'b0, "R9 idle in reset", {busCyc, done}, 32'd0);
    reqValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(busCyc == 1'b0 && done == 1'b0, "R9 idle after reset", {busCyc, done}, 32'd0);
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 14; i++) runVec(VECS[i], 0, 1'b0);

    // R7 R10 wait states on odd long over 16-bit port
    runVec('{2'd1, 3'd4, 3'd2, 1'b0, 32'h0, 3'd3}, 3, 1'b0);
    // R8 request poked while busy
    runVec('{2'd3, 3'd4, 3'd1, 1'b1, 32'h0BADF00D, 3'd4}, 0, 1'b1);

    // R11 request held across done, accepted in the done cycle
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    reqAddr = BASE + 32'd2; reqSize = 2'b01; reqWrite = 1'b1;
    reqWData = 32'h0000_005A; reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    check(busCyc && busAddr == BASE + 32'd2, "R11 first operand cycle", busAddr, BASE + 32'd2);
    mem[2] = busWData[15:8];
    busAck = 1'b1; busPortSize = 2'b00;
    @(posedge clk); @(negedge clk);
    busAck = 1'b0;
    check(done == 1'b1, "R11 done of first operand", 32'(done), 32'd1);
    reqAddr = BASE + 32'd3; reqWData = 32'h0000_00C3;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(busCyc && busAddr == BASE + 32'd3, "R11 second operand starts after done",
          busAddr, BASE + 32'd3);
    mem[3] = busWData[7:0];
    busAck = 1'b1; busPortSize = 2'b00;
    @(posedge clk); @(negedge clk);
    busAck = 1'b0;
    check(done == 1'b1, "R11 done of second operand", 32'(done), 32'd1);
    check(mem[2] == 8'h5A && mem[3] == 8'hC3, "R11 both bytes written",
          {16'h0, mem[2], mem[3]}, 32'h5AC3);
    @(negedge clk);
    check(busCyc == 1'b0, "R11 no third operand", 32'(busCyc), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule